// File: doc/BRIEF.md
# Fixed-Latency Load Return Controller

This block sits between an in-order pipeline and a memory whose response time varies. Software programs a latency value. The block then delivers every load to the pipeline exactly that many cycles after the load was issued, so a static code schedule can rely on it. Each accepted load takes a slot in a small circular buffer. The slot's index is the tag sent with the memory request. The slot also records the load's due time, which is measured on an internal time counter.

Memory may answer in any order. An answer that comes before the due time waits in its slot. If the due time of the oldest load comes and its data is still missing, the block raises a stall. It also freezes its time counter, so the loads behind keep their spacing relative to one another. The pipeline stops issuing while the stall is high.

Top module: `fixlat_load_ctrl`

## Requirements
- R1: After reset, `ld_ready` is 1, and `wb_valid`, `stall` and `mem_req_valid` are 0. The latency register holds 4.
- R2: A load accepted in cycle c, whose response arrives no later than cycle c+L-1, produces exactly one `wb_valid` pulse, in cycle c+L. L is the latency register value when the load was accepted.
- R3: Data that arrives early is held in the block. It appears on `wb_data`, together with the load's tag on `wb_tag`, in the writeback cycle.
- R4: If the response for the oldest load has not arrived by its due cycle, `stall` is 1 from that cycle up to and including the cycle in which the response arrives. Writeback happens in the following cycle. For a response in cycle c+d with d ≥ L, there are d+1-L stall cycles and writeback is in cycle c+d+1.
- R5: While `stall` is 1, due times do not advance. A younger load that is already outstanding, and whose data is present, writes back as many cycles late as the stall lasted.
- R6: At most 8 loads are outstanding. With 8 outstanding, `ld_ready` is 0 and no memory request is issued.
- R7: Tags are handed out in issue order, counting modulo 8 from 0 after reset. Responses may carry any outstanding tag, in any order. Writebacks leave in issue order, at most one per cycle.
- R8: The latency register accepts 1 to 31. A write of 0 stores 1. A write in cycle w applies to loads accepted from cycle w+1 on, and loads that are already outstanding keep their due times.
- R9: After the latency is lowered, a new load is refused (`ld_ready` 0) while its due time would not come after the due time of the youngest outstanding load. This keeps writeback order equal to issue order.
- R10: While `stall` is 1, `ld_ready` is 0 and `mem_req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lat_we | input | 1 | Latency register write strobe |
| lat_wdata | input | 5 | Latency value to write (0 stored as 1) |
| ld_valid | input | 1 | Pipeline offers a load this cycle |
| ld_addr | input | 32 | Load address |
| ld_ready | output | 1 | Load accepted when high together with `ld_valid` |
| mem_req_valid | output | 1 | Memory request issued this cycle |
| mem_req_addr | output | 32 | Request address |
| mem_req_tag | output | 3 | Request tag (slot index) |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_tag | input | 3 | Tag of the response |
| mem_rsp_data | input | 32 | Response data |
| wb_valid | output | 1 | Load result delivered this cycle |
| wb_tag | output | 3 | Tag of the delivered load |
| wb_data | output | 32 | Delivered data |
| stall | output | 1 | Pipeline must hold |

## Verification
The bench sweeps response delays across the whole latency range. It aims at the boundary where data arrives in the due cycle itself. A design that bypassed data in that cycle would deliver one cycle early and skip the stall, and one that counted stall cycles badly would be off by one. The bench fills all eight slots and answers them in reverse order, so a design that released writebacks in arrival order, or accepted a ninth load, produces the wrong data sequence. A late oldest load with an early younger load behind it tests the frozen time base: if the counter kept running, the younger load would come out in the same cycle or too soon. The bench lowers the latency while a long load is outstanding. A design that recomputed old due times, or let the new load overtake the old one, breaks the writeback cycles or their order.

// File: rtl/fixlat_pkg.sv
// Shared types for the fixed-latency load return controller.
// Assumes: nothing beyond IEEE 1800-2017.
package fixlat_pkg;

    // Lifecycle of one outstanding-load slot.
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,   // free
        SLOT_PEND = 2'd1,   // request sent, data not yet back
        SLOT_HELD = 2'd2    // data back, waiting for its due time
    } slot_st_e;

endpackage

// File: rtl/fl_timebase.sv
// Time base and latency register.
// The time counter advances every cycle unless frozen by a stall.
// The latency register never holds 0: a write of 0 is stored as 1.
// Assumes RESET_LAT is within 1 .. 2**LAT_W-1.
module fl_timebase #(
    parameter int LAT_W     = 5,
    parameter int CNT_W     = 7,
    parameter int RESET_LAT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze,
    input  logic             lat_we,
    input  logic [LAT_W-1:0] lat_wdata,
    output logic [CNT_W-1:0] now,
    output logic [LAT_W-1:0] lat_q
);
    localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);
    localparam logic [LAT_W-1:0] LAT_RST = LAT_W'(RESET_LAT);

    // Latency register update, with 0 promoted to 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_q <= LAT_RST;
        else if (lat_we)
            lat_q <= (lat_wdata == '0) ? LAT_ONE : lat_wdata;
    end

    // Time counter; holds while the pipeline is stalled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            now <= '0;
        else if (!freeze)
            now <= now + 1'b1;
    end

endmodule

// File: rtl/fl_slot_buf.sv
// Slot storage: one entry per tag, holding state, due time and data.
// Allocation writes the due time, a matching response fills the data,
// and retire frees the slot at the read index.
// Assumes: retire only on a HELD slot, and allocation only on a free slot.
// A response for a slot that is not pending is dropped.
module fl_slot_buf
    import fixlat_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int CNT_W  = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [TAG_W-1:0]  alloc_idx,
    input  logic [CNT_W-1:0]  alloc_due,
    input  logic              fill,
    input  logic [TAG_W-1:0]  fill_idx,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              retire,
    input  logic [TAG_W-1:0]  rd_idx,
    output slot_st_e          rd_state,
    output logic [CNT_W-1:0]  rd_due,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << TAG_W;

    slot_st_e          st_v  [DEPTH];
    logic [CNT_W-1:0]  due_v [DEPTH];
    logic [DATA_W-1:0] dat_v [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        slot_st_e          st_q;
        logic [CNT_W-1:0]  due_q;
        logic [DATA_W-1:0] dat_q;

        // Per-slot state machine: allocate, fill, retire.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q  <= SLOT_IDLE;
                due_q <= '0;
                dat_q <= '0;
            end else if (alloc && alloc_idx == TAG_W'(g)) begin
                st_q  <= SLOT_PEND;
                due_q <= alloc_due;
            end else if (retire && rd_idx == TAG_W'(g)) begin
                st_q  <= SLOT_IDLE;
            end else if (fill && fill_idx == TAG_W'(g) && st_q == SLOT_PEND) begin
                st_q  <= SLOT_HELD;
                dat_q <= fill_data;
            end
        end

        assign st_v[g]  = st_q;
        assign due_v[g] = due_q;
        assign dat_v[g] = dat_q;
    end

    assign rd_state = st_v[rd_idx];
    assign rd_due   = due_v[rd_idx];
    assign rd_data  = dat_v[rd_idx];

endmodule

// File: rtl/fl_order_ctl.sv
// Issue-order bookkeeping: write/read pointers, occupancy and the due
// time of the youngest load. Computes the due time of a new load and
// whether that time keeps the due times strictly increasing.
// Assumes the outstanding due times span less than half the counter range.
module fl_order_ctl #(
    parameter int TAG_W = 3,
    parameter int CNT_W = 7,
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic             retire,
    input  logic [CNT_W-1:0] now,
    input  logic [LAT_W-1:0] lat,
    output logic [TAG_W-1:0] wr_ptr,
    output logic [TAG_W-1:0] rd_ptr,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] new_due,
    output logic             order_ok
);
    localparam int DEPTH = 1 << TAG_W;

    logic [TAG_W:0]   count;
    logic [CNT_W-1:0] last_due;
    logic [CNT_W-1:0] gap;

    assign new_due  = now + CNT_W'(lat);
    assign gap      = new_due - last_due;
    assign full     = (count == (TAG_W+1)'(DEPTH));
    assign empty    = (count == '0);
    assign order_ok = empty || (!gap[CNT_W-1] && gap != '0);

    // Pointer, occupancy and youngest-due tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            last_due <= '0;
        end else begin
            if (issue) begin
                wr_ptr   <= wr_ptr + 1'b1;
                last_due <= new_due;
            end
            if (retire)
                rd_ptr <= rd_ptr + 1'b1;
            unique case ({issue, retire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/fixlat_load_ctrl.sv
// Fixed-latency load return controller (top).
// Makes each load reach the pipeline exactly lat_q cycles after issue.
// Early data waits in its slot, and missing data stalls the pipeline and
// freezes the time base. Tag = slot index, and writebacks leave in issue order.
// Assumes memory answers each request once, no earlier than the cycle
// after the request.
module fixlat_load_ctrl #(
    parameter int TAG_W     = 3,
    parameter int LAT_W     = 5,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int RESET_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_we,
    input  logic [LAT_W-1:0]  lat_wdata,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_ready,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [TAG_W-1:0]  mem_req_tag,
    input  logic              mem_rsp_valid,
    input  logic [TAG_W-1:0]  mem_rsp_tag,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              wb_valid,
    output logic [TAG_W-1:0]  wb_tag,
    output logic [DATA_W-1:0] wb_data,
    output logic              stall
);
    import fixlat_pkg::*;

    localparam int CNT_W = LAT_W + 2;

    logic [CNT_W-1:0] now;
    logic [LAT_W-1:0] lat_q;
    logic [TAG_W-1:0] wr_ptr;
    logic [TAG_W-1:0] rd_ptr;
    logic             full;
    logic             empty;
    logic [CNT_W-1:0] new_due;
    logic             order_ok;
    slot_st_e         head_st;
    logic [CNT_W-1:0] head_due;
    logic             head_due_now;
    logic             issue;

    // Head-of-line decisions: deliver, or stall when data is missing.
    assign head_due_now  = !empty && (head_due == now);
    assign wb_valid      = head_due_now && (head_st == SLOT_HELD);
    assign stall         = head_due_now && (head_st != SLOT_HELD);
    assign ld_ready      = !full && !stall && order_ok;
    assign issue         = ld_valid && ld_ready;
    assign mem_req_valid = issue;
    assign mem_req_addr  = ld_addr;
    assign mem_req_tag   = wr_ptr;
    assign wb_tag        = rd_ptr;

    fl_timebase #(
        .LAT_W     (LAT_W),
        .CNT_W     (CNT_W),
        .RESET_LAT (RESET_LAT)
    ) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .freeze    (stall),
        .lat_we    (lat_we),
        .lat_wdata (lat_wdata),
        .now       (now),
        .lat_q     (lat_q)
    );

    fl_order_ctl #(
        .TAG_W (TAG_W),
        .CNT_W (CNT_W),
        .LAT_W (LAT_W)
    ) u_order (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue),
        .retire   (wb_valid),
        .now      (now),
        .lat      (lat_q),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .full     (full),
        .empty    (empty),
        .new_due  (new_due),
        .order_ok (order_ok)
    );

    fl_slot_buf #(
        .TAG_W  (TAG_W),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (issue),
        .alloc_idx (wr_ptr),
        .alloc_due (new_due),
        .fill      (mem_rsp_valid),
        .fill_idx  (mem_rsp_tag),
        .fill_data (mem_rsp_data),
        .retire    (wb_valid),
        .rd_idx    (rd_ptr),
        .rd_state  (head_st),
        .rd_due    (head_due),
        .rd_data   (wb_data)
    );

endmodule

// File: rtl/fixlat_load_ctrl_chk.sv
// Property checker for fixlat_load_ctrl, attached with bind below.
// Observes ports plus the internal time counter, latency register and
// full flag.
module fixlat_load_ctrl_chk #(
    parameter int TAG_W = 3,
    parameter int LAT_W = 5,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stall,
    input logic             wb_valid,
    input logic [TAG_W-1:0] wb_tag,
    input logic             ld_ready,
    input logic             mem_req_valid,
    input logic             mem_rsp_valid,
    input logic [TAG_W-1:0] mem_rsp_tag,
    input logic             full,
    input logic [CNT_W-1:0] now,
    input logic [LAT_W-1:0] lat_q
);
    // R4: a stall persists until the head's data arrives
    assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !(mem_rsp_valid && mem_rsp_tag == wb_tag)) |=> stall);

    // R4: delivery and stall never coincide
    assert_wb_not_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_valid && stall));

    // R5: time base frozen across a stalled cycle
    assert_time_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (now == $past(now)));

    // R6: no acceptance with all slots busy
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (!ld_ready && !mem_req_valid));

    // R7: back-to-back writebacks carry consecutive tags
    assert_wb_in_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && $past(wb_valid)) |-> (wb_tag == TAG_W'($past(wb_tag) + 1'b1)));

    // R8: latency register never zero
    assert_lat_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lat_q != '0);

    // R10: no issue while stalled
    assert_no_issue_in_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!ld_ready && !mem_req_valid));

endmodule

bind fixlat_load_ctrl fixlat_load_ctrl_chk #(
    .TAG_W (TAG_W),
    .LAT_W (LAT_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall         (stall),
    .wb_valid      (wb_valid),
    .wb_tag        (wb_tag),
    .ld_ready      (ld_ready),
    .mem_req_valid (mem_req_valid),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_tag   (mem_rsp_tag),
    .full          (full),
    .now           (now),
    .lat_q         (lat_q)
);

// File: tb/fixlat_load_ctrl_bench.sv
`timescale 1ns/100ps
module fixlat_load_ctrl_bench;
    localparam int TAG_W  = 3;
    localparam int LAT_W  = 5;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 32;

    typedef struct packed {
        logic [4:0]  lat;
        logic [7:0]  dly;
        logic [31:0] data;
    } vec_t;

    // latency written, response delay after issue, data returned
    localparam vec_t VECS [10] = '{
        '{5'd4,  8'd1,  32'hA000_0001},
        '{5'd4,  8'd3,  32'hA000_0002},
        '{5'd4,  8'd4,  32'hA000_0003},
        '{5'd4,  8'd7,  32'hA000_0004},
        '{5'd1,  8'd1,  32'hA000_0005},
        '{5'd1,  8'd5,  32'hA000_0006},
        '{5'd31, 8'd2,  32'hA000_0007},
        '{5'd31, 8'd30, 32'hA000_0008},
        '{5'd31, 8'd33, 32'hA000_0009},
        '{5'd0,  8'd1,  32'hA000_000A}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lat_we = 1'b0;
    logic [LAT_W-1:0]  lat_wdata = '0;
    logic              ld_valid = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic              ld_ready;
    logic              mem_req_valid;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [TAG_W-1:0]  mem_req_tag;
    logic              mem_rsp_valid = 1'b0;
    logic [TAG_W-1:0]  mem_rsp_tag = '0;
    logic [DATA_W-1:0] mem_rsp_data = '0;
    logic              wb_valid;
    logic [TAG_W-1:0]  wb_tag;
    logic [DATA_W-1:0] wb_data;
    logic              stall;

    always #2.5 clk = ~clk;

    fixlat_load_ctrl u_fixlat_load_ctrl (
        .clk (clk), .rst_n (rst_n),
        .lat_we (lat_we), .lat_wdata (lat_wdata),
        .ld_valid (ld_valid), .ld_addr (ld_addr), .ld_ready (ld_ready),
        .mem_req_valid (mem_req_valid), .mem_req_addr (mem_req_addr),
        .mem_req_tag (mem_req_tag),
        .mem_rsp_valid (mem_rsp_valid), .mem_rsp_tag (mem_rsp_tag),
        .mem_rsp_data (mem_rsp_data),
        .wb_valid (wb_valid), .wb_tag (wb_tag), .wb_data (wb_data),
        .stall (stall)
    );

    int total = 0;
    int bad   = 0;
    int exp_tag = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_lat(input logic [LAT_W-1:0] v);
        @(negedge clk); lat_we = 1'b1; lat_wdata = v; #1;
        @(negedge clk); lat_we = 1'b0; #1;
    endtask

    // One isolated load from the vector table
    task automatic run_one(input vec_t v);
        int l_eff, exp_wb, exp_st, wb_at, stalls, nwb;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] got;
        string req;
        l_eff  = (v.lat == 0) ? 1 : int'(v.lat);
        exp_wb = (int'(v.dly) + 1 > l_eff) ? int'(v.dly) + 1 : l_eff;
        exp_st = exp_wb - l_eff;
        req    = (v.lat == 0) ? "R8" : ((int'(v.dly) >= l_eff) ? "R4" : "R2");
        set_lat(v.lat);
        @(negedge clk); ld_valid = 1'b1; ld_addr = v.data; #1;
        check(ld_ready && mem_req_valid, "R2", "load accepted", ld_ready, 1);
        check(mem_req_tag == exp_tag[TAG_W-1:0], "R7", "issue tag", mem_req_tag, exp_tag);
        check(mem_req_addr == v.data, "R2", "request address", mem_req_addr, v.data);
        tag = mem_req_tag;
        exp_tag = (exp_tag + 1) % 8;
        wb_at = -1; stalls = 0; nwb = 0; got = '0;
        for (int k = 1; k <= 70; k++) begin
            @(negedge clk);
            ld_valid = 1'b0;
            mem_rsp_valid = (k == int'(v.dly));
            mem_rsp_tag = tag;
            mem_rsp_data = v.data;
            #1;
            if (stall) stalls++;
            if (wb_valid) begin
                nwb++;
                if (wb_at < 0) begin wb_at = k; got = wb_data; end
            end
        end
        mem_rsp_valid = 1'b0;
        check(wb_at == exp_wb, req, "writeback cycle", wb_at, exp_wb);
        check(nwb == 1, "R2", "writeback count", nwb, 1);
        check(got == v.data, "R3", "writeback data", got, v.data);
        check(stalls == exp_st, "R4", "stall cycles", stalls, exp_st);
    endtask

    // Fill all slots, answer in reverse order
    task automatic fill_test();
        logic [TAG_W-1:0] tags [8];
        int nwb;
        set_lat(5'd20);
        nwb = 0;
        for (int k = 0; k <= 32; k++) begin
            @(negedge clk);
            ld_valid = (k <= 8);
            ld_addr = 32'h100 + k;
            mem_rsp_valid = (k >= 9 && k <= 16);
            if (k >= 9 && k <= 16) begin
                mem_rsp_tag  = tags[16 - k];
                mem_rsp_data = 32'hB000_0000 + (16 - k);
            end
            #1;
            if (k <= 7) begin
                check(ld_ready, "R6", "accept while slots free", ld_ready, 1);
                check(mem_req_tag == exp_tag[TAG_W-1:0], "R7", "fill tag", mem_req_tag, exp_tag);
                tags[k] = mem_req_tag;
                exp_tag = (exp_tag + 1) % 8;
            end
            if (k == 8) begin
                check(!ld_ready, "R6", "ready with 8 outstanding", ld_ready, 0);
                check(!mem_req_valid, "R6", "request with 8 outstanding", mem_req_valid, 0);
            end
            if (wb_valid) begin
                check(k == 20 + nwb, "R7", "in-order wb cycle", k, 20 + nwb);
                check(wb_data == 32'hB000_0000 + nwb, "R7", "in-order wb data",
                      wb_data, 32'hB000_0000 + nwb);
                check(wb_tag == tags[nwb], "R7", "in-order wb tag", wb_tag, tags[nwb]);
                nwb++;
            end
        end
        mem_rsp_valid = 1'b0;
        check(nwb == 8, "R7", "writebacks after fill", nwb, 8);
    endtask

    // Late older load, early younger load: time base freeze
    task automatic freeze_test();
        logic [TAG_W-1:0] ta, tb;
        int wa, wbb, stalls;
        set_lat(5'd3);
        wa = -1; wbb = -1; stalls = 0; ta = '0; tb = '0;
        for (int k = 0; k <= 14; k++) begin
            @(negedge clk);
            ld_valid = (k <= 1) || (k == 4);
            ld_addr = 32'h200 + k;
            mem_rsp_valid = (k == 2) || (k == 5);
            mem_rsp_tag  = (k == 2) ? tb : ta;
            mem_rsp_data = (k == 2) ? 32'hC000_000B : 32'hC000_000A;
            #1;
            if (k == 0) begin ta = mem_req_tag; exp_tag = (exp_tag + 1) % 8; end
            if (k == 1) begin
                check(ld_ready, "R5", "second load accepted", ld_ready, 1);
                tb = mem_req_tag; exp_tag = (exp_tag + 1) % 8;
            end
            if (k == 4) begin
                check(!ld_ready, "R10", "ready during stall", ld_ready, 0);
                check(!mem_req_valid, "R10", "request during stall", mem_req_valid, 0);
            end
            if (stall) stalls++;
            if (wb_valid && wb_data == 32'hC000_000A) wa = k;
            if (wb_valid && wb_data == 32'hC000_000B) wbb = k;
        end
        mem_rsp_valid = 1'b0;
        check(stalls == 3, "R4", "stall cycles late head", stalls, 3);
        check(wa == 6, "R4", "late head wb cycle", wa, 6);
        check(wbb == 7, "R5", "younger wb after frozen time", wbb, 7);
    endtask

    // Lower latency while a long load is outstanding
    task automatic lower_test();
        int acc, wa, wbb, refused;
        logic [TAG_W-1:0] ta, tb;
        set_lat(5'd10);
        acc = -1; wa = -1; wbb = -1; refused = 0; ta = '0; tb = '0;
        for (int k = 0; k <= 20; k++) begin
            @(negedge clk);
            ld_valid  = (k == 0) || (k >= 2 && acc < 0);
            ld_addr   = 32'h300 + k;
            lat_we    = (k == 1);
            lat_wdata = 5'd3;
            mem_rsp_valid = (k == 1) || (acc >= 0 && k == acc + 1);
            mem_rsp_tag   = (k == 1) ? ta : tb;
            mem_rsp_data  = (k == 1) ? 32'hD000_000A : 32'hD000_000B;
            #1;
            if (k == 0) begin ta = mem_req_tag; exp_tag = (exp_tag + 1) % 8; end
            if (k >= 2 && acc < 0) begin
                if (ld_ready) begin
                    acc = k; tb = mem_req_tag; exp_tag = (exp_tag + 1) % 8;
                end else refused++;
            end
            if (wb_valid && wb_data == 32'hD000_000A) wa = k;
            if (wb_valid && wb_data == 32'hD000_000B) wbb = k;
        end
        lat_we = 1'b0;
        mem_rsp_valid = 1'b0;
        check(acc == 8, "R9", "first accept after lowering", acc, 8);
        check(refused == 6, "R9", "refused cycles", refused, 6);
        check(wa == 10, "R8", "old load keeps latency", wa, 10);
        check(wbb == 11, "R8", "new load uses new latency", wbb, 11);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(ld_ready == 1'b1, "R1", "ld_ready after reset", ld_ready, 1);
        check(wb_valid == 1'b0, "R1", "wb_valid after reset", wb_valid, 0);
        check(stall == 1'b0, "R1", "stall after reset", stall, 0);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", mem_req_valid, 0);
        // R1: reset latency 4, load answered next cycle
        @(negedge clk); ld_valid = 1'b1; ld_addr = 32'h4; #1;
        check(mem_req_tag == 0, "R1", "first tag after reset", mem_req_tag, 0);
        exp_tag = 1;
        begin
            int wat;
            wat = -1;
            for (int k = 1; k <= 10; k++) begin
                @(negedge clk);
                ld_valid = 1'b0;
                mem_rsp_valid = (k == 1);
                mem_rsp_tag = '0;
                mem_rsp_data = 32'h1234;
                #1;
                if (wb_valid && wat < 0) wat = k;
            end
            mem_rsp_valid = 1'b0;
            check(wat == 4, "R1", "reset latency wb cycle", wat, 4);
        end
        for (int i = 0; i < 10; i++) run_one(VECS[i]);
        fill_test();
        freeze_test();
        lower_test();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule